// File: doc/BRIEF.md
# USB Device Transmit Endpoint Control

This block holds the control and status logic of a single transmit endpoint in a USB device controller. Software programs an 8-bit control byte over a simple write/read bus. The block tracks how many bytes have been pushed into the endpoint's transmit FIFO against a programmed maximum packet size. It keeps the packet-ready flag and the endpoint data toggle. It also drives a DMA request and an interrupt. The link layer reports handshakes back through two strobes: ACK received and packet sent.

A two-state machine sits at the centre. In `ST_FILL` the packet is being loaded and the ready flag is low. In `ST_READY` a packet is waiting for the link to take it. The transitions are:
- `FILL_TO_READY`: a software set, or an automatic set when a full packet has been loaded with auto-arm enabled.
- `READY_TO_FILL_ACK`: an ACK on a bulk or interrupt endpoint. The toggle flips.
- `READY_TO_FILL_SENT`: a sent packet on an isochronous endpoint. The toggle is kept.
- `ANY_TO_FILL_FORCE`: a forced toggle from either state. The toggle flips and the packet is flushed.

Leaving `ST_READY` clears the byte count.

Top module: `usb_tx_ep_ctrl`

## Requirements
- R1: After reset all control fields read 0. The control byte layout is bit 7 auto-arm, bit 6 isochronous, bit 5 direction, bit 4 DMA enable, bit 3 force-toggle, bit 2 DMA interrupt mode, and bits 1:0 reserved. Bits 7, 6, 5, 4 and 2 read back as last written. Bits 3, 1 and 0 always read 0.
- R2: With auto-arm=1 in `ST_FILL`, the push that brings the byte count to `max_pkt` sets `stat_txrdy` at that clock edge.
- R3: A load shorter than `max_pkt` never sets `stat_txrdy`. With auto-arm=0, even a full load does not set it. A `sw_set_rdy` pulse in `ST_FILL` sets it.
- R4: On a bulk or interrupt endpoint (isochronous=0), `link_ack` in `ST_READY` clears `stat_txrdy` and inverts `stat_toggle`. `link_sent` is ignored.
- R5: On an isochronous endpoint, `link_sent` in `ST_READY` clears `stat_txrdy` and leaves `stat_toggle` unchanged. `link_ack` is ignored.
- R6: `iso_mode` follows the isochronous bit. With `shared_fifo`=1, `dir_tx` equals the direction bit. With `shared_fifo`=0, `dir_tx` is 1 whatever that bit holds.
- R7: `dma_req` is high exactly when DMA enable=1, `stat_txrdy`=0, `fifo_room`=1 and the byte count is below `max_pkt`. It is therefore 0 once a full packet is loaded, and always 0 with DMA enable=0.
- R8: A write with bit 3 = 1 inverts `stat_toggle`, clears `stat_txrdy` and the byte count from either state, and pulses `flush` high for the following cycle. This happens whether or not an ACK arrived. A write with bit 3 = 0 changes neither the toggle nor the ready flag.
- R9: With DMA interrupt mode=0 and DMA enable=1, `irq` is high for the one cycle after a push completes a packet, and `dma_done` is ignored.
- R10: With DMA interrupt mode=1 and DMA enable=1, `irq` is high for the one cycle after `dma_done`, and packet completion raises no interrupt. With DMA enable=0, `irq` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Control byte write strobe |
| reg_wdata | input | 8 | Control byte write data |
| reg_rdata | output | 8 | Control byte readback |
| sw_set_rdy | input | 1 | Software packet-ready set pulse |
| fifo_push | input | 1 | One byte loaded into the transmit FIFO |
| fifo_room | input | 1 | FIFO has room for a full packet |
| max_pkt | input | CW | Programmed maximum packet size in bytes |
| shared_fifo | input | 1 | FIFO shared between transmit and receive |
| link_ack | input | 1 | ACK received from host |
| link_sent | input | 1 | Packet transmitted on the bus |
| dma_done | input | 1 | Whole DMA transfer finished |
| dma_req | output | 1 | DMA request for this endpoint |
| irq | output | 1 | DMA interrupt pulse |
| flush | output | 1 | Discard current FIFO packet |
| dir_tx | output | 1 | Effective endpoint direction, 1 = transmit |
| iso_mode | output | 1 | Endpoint in isochronous operation |
| stat_toggle | output | 1 | Current data toggle |
| stat_txrdy | output | 1 | Packet-ready flag |

## Verification
The assertions assume three things about the inputs:
- `max_pkt` is at least 1 and does not change while a packet is loading.
- Handshake strobes are single-cycle pulses.
- `dma_done` only arrives while DMA is enabled if an interrupt is expected.

The stimulus keeps within these limits. It reprograms `max_pkt` only between packets, when the count has been cleared. It drives every strobe for exactly one cycle. It sweeps packet sizes 1 to 6 across all sixteen combinations of auto-arm, isochronous, DMA enable and interrupt mode, with `fifo_room` held high except in a dedicated check.

// File: rtl/txep_pkg.sv
package txep_pkg;

    typedef struct packed {
        logic autoarm;
        logic iso;
        logic dir;
        logic dmaen;
        logic dmamode;
    } ep_cfg_t;

    typedef enum logic {
        ST_FILL  = 1'b0,
        ST_READY = 1'b1
    } ep_state_t;

endpackage

// File: rtl/txep_cfg_reg.sv
module txep_cfg_reg
    import txep_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       reg_wr,
    input  logic [7:0] reg_wdata,
    output logic [7:0] reg_rdata,
    output ep_cfg_t    cfg,
    output logic       force_stb
);

    ep_cfg_t cfg_q;
    logic    unused_rsvd;

    assign unused_rsvd = ^reg_wdata[1:0];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else if (reg_wr) begin
            cfg_q.autoarm <= reg_wdata[7];
            cfg_q.iso     <= reg_wdata[6];
            cfg_q.dir     <= reg_wdata[5];
            cfg_q.dmaen   <= reg_wdata[4];
            cfg_q.dmamode <= reg_wdata[2];
        end
    end

    assign force_stb = reg_wr & reg_wdata[3];
    assign cfg       = cfg_q;
    assign reg_rdata = {cfg_q.autoarm, cfg_q.iso, cfg_q.dir, cfg_q.dmaen,
                        1'b0, cfg_q.dmamode, 2'b00};

    // R1: a write is reflected in the readback on the next cycle
    a_r1_write_back: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr |=> (reg_rdata[7:4] == $past(reg_wdata[7:4])) && (reg_rdata[2] == $past(reg_wdata[2])));

endmodule

// File: rtl/txep_pkt_fsm.sv
module txep_pkt_fsm
    import txep_pkg::*;
#(
    parameter int CW = 11
) (
    input  logic          clk,
    input  logic          rst_n,
    input  ep_cfg_t       cfg,
    input  logic          force_stb,
    input  logic          sw_set_rdy,
    input  logic          fifo_push,
    input  logic [CW-1:0] max_pkt,
    input  logic          link_ack,
    input  logic          link_sent,
    output logic          txrdy,
    output logic          toggle,
    output logic          room_left,
    output logic          pkt_done,
    output logic          flush
);

    localparam logic [CW-1:0] CNT_ONE = CW'(1);

    ep_state_t     st_q, st_d;
    logic [CW-1:0] cnt_q, cnt_d, cnt_inc;
    logic          tog_q, tog_d;
    logic          flush_q;
    logic          fill_hit;

    assign cnt_inc  = cnt_q + CNT_ONE;
    assign fill_hit = fifo_push && (cnt_q < max_pkt) && (cnt_inc == max_pkt);
    assign pkt_done = (st_q == ST_FILL) && !force_stb && fill_hit;

    always_comb begin
        st_d  = st_q;
        cnt_d = cnt_q;
        tog_d = tog_q;
        if (force_stb) begin
            st_d  = ST_FILL;
            cnt_d = '0;
            tog_d = ~tog_q;
        end else begin
            unique case (st_q)
                ST_FILL: begin
                    if (fifo_push && (cnt_q < max_pkt)) cnt_d = cnt_inc;
                    if (sw_set_rdy || (cfg.autoarm && fill_hit)) st_d = ST_READY;
                end
                ST_READY: begin
                    if (!cfg.iso && link_ack) begin
                        st_d  = ST_FILL;
                        cnt_d = '0;
                        tog_d = ~tog_q;
                    end else if (cfg.iso && link_sent) begin
                        st_d  = ST_FILL;
                        cnt_d = '0;
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q    <= ST_FILL;
            cnt_q   <= '0;
            tog_q   <= 1'b0;
            flush_q <= 1'b0;
        end else begin
            st_q    <= st_d;
            cnt_q   <= cnt_d;
            tog_q   <= tog_d;
            flush_q <= force_stb;
        end
    end

    assign txrdy     = (st_q == ST_READY);
    assign toggle    = tog_q;
    assign room_left = (cnt_q < max_pkt);
    assign flush     = flush_q;

    // R2: auto-arm sets ready on the completing push
    a_r2_autoarm: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_FILL && cfg.autoarm && fill_hit && !force_stb) |=> (st_q == ST_READY));
    // R3: no software set and no automatic set keeps the endpoint filling
    a_r3_no_auto: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_FILL && !sw_set_rdy && !(cfg.autoarm && fill_hit)) |=> (st_q == ST_FILL));
    // R4: ACK on a non-isochronous endpoint advances toggle and frees the slot
    a_r4_ack: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_READY && !cfg.iso && link_ack && !force_stb) |=> (st_q == ST_FILL && tog_q != $past(tog_q)));
    // R5: an isochronous endpoint never moves the toggle by itself
    a_r5_iso_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg.iso && !force_stb) |=> $stable(tog_q));
    // R8: forced toggle flips and empties from any state
    a_r8_force: assert property (@(posedge clk) disable iff (!rst_n)
        force_stb |=> (tog_q != $past(tog_q)) && (st_q == ST_FILL) && (cnt_q == '0) && flush);

endmodule

// File: rtl/txep_dma_irq.sv
module txep_dma_irq
    import txep_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  ep_cfg_t cfg,
    input  logic    txrdy,
    input  logic    fifo_room,
    input  logic    room_left,
    input  logic    pkt_done,
    input  logic    dma_done,
    output logic    dma_req,
    output logic    irq
);

    logic irq_q;

    assign dma_req = cfg.dmaen && !txrdy && fifo_room && room_left;

    always_ff @(posedge clk) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= cfg.dmaen && (cfg.dmamode ? dma_done : pkt_done);
    end

    assign irq = irq_q;

    // R9: per-packet mode does not react to the transfer-done input
    a_r9_pkt_mode: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg.dmamode && !pkt_done) |=> !irq);
    // R10: whole-transfer mode raises nothing without transfer done
    a_r10_xfer_mode: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg.dmamode && !dma_done) |=> !irq);

endmodule

// File: rtl/usb_tx_ep_ctrl.sv
module usb_tx_ep_ctrl
    import txep_pkg::*;
#(
    parameter int CW = 11
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_wr,
    input  logic [7:0]    reg_wdata,
    output logic [7:0]    reg_rdata,
    input  logic          sw_set_rdy,
    input  logic          fifo_push,
    input  logic          fifo_room,
    input  logic [CW-1:0] max_pkt,
    input  logic          shared_fifo,
    input  logic          link_ack,
    input  logic          link_sent,
    input  logic          dma_done,
    output logic          dma_req,
    output logic          irq,
    output logic          flush,
    output logic          dir_tx,
    output logic          iso_mode,
    output logic          stat_toggle,
    output logic          stat_txrdy
);

    ep_cfg_t cfg;
    logic    force_stb;
    logic    room_left;
    logic    pkt_done;

    txep_cfg_reg u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .cfg       (cfg),
        .force_stb (force_stb)
    );

    txep_pkt_fsm #(.CW(CW)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg        (cfg),
        .force_stb  (force_stb),
        .sw_set_rdy (sw_set_rdy),
        .fifo_push  (fifo_push),
        .max_pkt    (max_pkt),
        .link_ack   (link_ack),
        .link_sent  (link_sent),
        .txrdy      (stat_txrdy),
        .toggle     (stat_toggle),
        .room_left  (room_left),
        .pkt_done   (pkt_done),
        .flush      (flush)
    );

    txep_dma_irq u_dma (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg       (cfg),
        .txrdy     (stat_txrdy),
        .fifo_room (fifo_room),
        .room_left (room_left),
        .pkt_done  (pkt_done),
        .dma_done  (dma_done),
        .dma_req   (dma_req),
        .irq       (irq)
    );

    assign dir_tx   = shared_fifo ? cfg.dir : 1'b1;
    assign iso_mode = cfg.iso;

    // R7: a completed packet withdraws the DMA request
    a_r7_req_stop: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_done |=> !dma_req);
    // R1: reserved and strobe bits never read back as 1
    a_r1_rsvd_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rdata[3] == 1'b0) && (reg_rdata[1:0] == 2'b00));

endmodule

// File: tb/test_usb_tx_ep_ctrl.sv
module test_usb_tx_ep_ctrl;

    localparam int CW = 11;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          reg_wr = 1'b0;
    logic [7:0]    reg_wdata = '0;
    logic [7:0]    reg_rdata;
    logic          sw_set_rdy = 1'b0;
    logic          fifo_push = 1'b0;
    logic          fifo_room = 1'b1;
    logic [CW-1:0] max_pkt = CW'(4);
    logic          shared_fifo = 1'b0;
    logic          link_ack = 1'b0;
    logic          link_sent = 1'b0;
    logic          dma_done = 1'b0;
    logic          dma_req, irq, flush, dir_tx, iso_mode, stat_toggle, stat_txrdy;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;
    logic exp_tog = 1'b0;

    always #10 clk = ~clk;

    usb_tx_ep_ctrl #(.CW(CW)) i_usb_tx_ep_ctrl (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .sw_set_rdy(sw_set_rdy), .fifo_push(fifo_push),
        .fifo_room(fifo_room), .max_pkt(max_pkt), .shared_fifo(shared_fifo),
        .link_ack(link_ack), .link_sent(link_sent), .dma_done(dma_done),
        .dma_req(dma_req), .irq(irq), .flush(flush), .dir_tx(dir_tx),
        .iso_mode(iso_mode), .stat_toggle(stat_toggle), .stat_txrdy(stat_txrdy)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
        reg_wr = 1'b0; sw_set_rdy = 1'b0; fifo_push = 1'b0;
        link_ack = 1'b0; link_sent = 1'b0; dma_done = 1'b0;
    endtask

    task automatic wr(input logic [7:0] d);
        reg_wr = 1'b1; reg_wdata = d;
        tick();
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        check("R1 reset rdata", reg_rdata, 8'h00);
        check("R1 reset txrdy", {7'b0, stat_txrdy}, 8'h0);
        check("R1 reset toggle", {7'b0, stat_toggle}, 8'h0);
        check("R1 reset irq/flush/req", {5'b0, irq, flush, dma_req}, 8'h0);

        wr(8'hFF);
        check("R1 readback masks bits 3,1,0", reg_rdata, 8'hF4);
        exp_tog = ~exp_tog;
        check("R8 toggle on full write", {7'b0, stat_toggle}, {7'b0, exp_tog});
        wr(8'h00);
        check("R1 clear readback", reg_rdata, 8'h00);

        // Sweep packet sizes and all mode combinations
        for (int mp = 1; mp <= 6; mp++) begin
            for (int c = 0; c < 16; c++) begin
                logic aa, is, de, dm;
                aa = c[0]; is = c[1]; de = c[2]; dm = c[3];
                max_pkt = CW'(mp);
                wr({aa, is, 1'b1, de, 1'b0, dm, 2'b00});
                check("R1 cfg readback", reg_rdata, {aa, is, 1'b1, de, 1'b0, dm, 2'b00});
                check("R6 iso_mode", {7'b0, iso_mode}, {7'b0, is});
                for (int b = 0; b < mp - 1; b++) begin
                    fifo_push = 1'b1;
                    tick();
                    check("R3 short load not ready", {7'b0, stat_txrdy}, 8'h0);
                    check("R9 no irq mid packet", {7'b0, irq}, 8'h0);
                end
                check("R7 req while loading", {7'b0, dma_req}, {7'b0, de});
                fifo_push = 1'b1;
                tick();
                check("R2/R3 full load ready", {7'b0, stat_txrdy}, {7'b0, aa});
                check("R9 per-packet irq", {7'b0, irq}, {7'b0, de & ~dm});
                check("R7 req drops at full", {7'b0, dma_req}, 8'h0);
                tick();
                check("R9 irq one cycle", {7'b0, irq}, 8'h0);
                if (!aa) begin
                    sw_set_rdy = 1'b1;
                    tick();
                    check("R3 software set", {7'b0, stat_txrdy}, 8'h1);
                end
                dma_done = 1'b1;
                tick();
                check("R10 transfer irq", {7'b0, irq}, {7'b0, de & dm});
                check("R7 no req while ready", {7'b0, dma_req}, 8'h0);
                if (is) begin
                    link_ack = 1'b1;
                    tick();
                    check("R5 ack ignored", {6'b0, stat_txrdy, stat_toggle}, {6'b0, 1'b1, exp_tog});
                    link_sent = 1'b1;
                    tick();
                    check("R5 sent clears, toggle kept", {6'b0, stat_txrdy, stat_toggle}, {6'b0, 1'b0, exp_tog});
                end else begin
                    link_sent = 1'b1;
                    tick();
                    check("R4 sent ignored", {6'b0, stat_txrdy, stat_toggle}, {6'b0, 1'b1, exp_tog});
                    link_ack = 1'b1;
                    tick();
                    exp_tog = ~exp_tog;
                    check("R4 ack clears and flips", {6'b0, stat_txrdy, stat_toggle}, {6'b0, 1'b0, exp_tog});
                end
            end
        end

        // Forced toggle: partial load, flush, count restart
        max_pkt = CW'(4);
        wr(8'h80);
        fifo_push = 1'b1; tick();
        fifo_push = 1'b1; tick();
        wr(8'h88);
        exp_tog = ~exp_tog;
        check("R8 force flips toggle", {7'b0, stat_toggle}, {7'b0, exp_tog});
        check("R8 flush pulse", {7'b0, flush}, 8'h1);
        check("R1 force bit reads 0", reg_rdata, 8'h80);
        tick();
        check("R8 flush one cycle", {7'b0, flush}, 8'h0);
        for (int b = 0; b < 3; b++) begin
            fifo_push = 1'b1; tick();
        end
        check("R8 count cleared by force", {7'b0, stat_txrdy}, 8'h0);
        fifo_push = 1'b1; tick();
        check("R2 ready after restart", {7'b0, stat_txrdy}, 8'h1);
        wr(8'h80);
        check("R8 zero force bit no effect", {6'b0, stat_txrdy, stat_toggle}, {6'b0, 1'b1, exp_tog});
        wr(8'h08);
        exp_tog = ~exp_tog;
        check("R8 force clears ready", {6'b0, stat_txrdy, stat_toggle}, {6'b0, 1'b0, exp_tog});

        // Direction and FIFO room
        wr(8'h10);
        shared_fifo = 1'b0; #1;
        check("R6 unshared forces tx", {7'b0, dir_tx}, 8'h1);
        shared_fifo = 1'b1; #1;
        check("R6 shared follows dir=0", {7'b0, dir_tx}, 8'h0);
        wr(8'h30); #1;
        check("R6 shared follows dir=1", {7'b0, dir_tx}, 8'h1);
        check("R7 req with room", {7'b0, dma_req}, 8'h1);
        fifo_room = 1'b0; #1;
        check("R7 no req without room", {7'b0, dma_req}, 8'h0);
        fifo_room = 1'b1;
        wr(8'h00); #1;
        check("R7 no req when disabled", {7'b0, dma_req}, 8'h0);
        dma_done = 1'b1; tick();
        check("R10 no irq when disabled", {7'b0, irq}, 8'h0);

        if (!finished) begin
            finished = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule